// File: doc/BRIEF.md
# Phase-Multiplexed Shared RAM Arbiter

This block lets two processor buses use one single-port synchronous RAM without ever stalling either side. A toggle register driven by the system clock produces a phase. Side A owns the RAM in every phase-0 cycle and side B owns it in every phase-1 cycle. There is no request/grant handshake. A side simply presents its access in its own phase, and the block routes that side's address, write data and write strobe to the RAM.

The RAM holds a number of equal banks. Each side decodes its own address into those banks, at different base addresses. On side A each bank sits at the bottom of a larger region and is mirrored through the rest of that region. On side B the banks are packed back to back with no mirroring. Each side gets a hit flag and a private flag. Its private-resource decoding can use the private flag to claim any access that misses the shared windows.

Top module: `phase_shared_ram`

## Requirements
- R1: `phase` is 0 while `rstN` is low and inverts on every rising clock edge after reset.
- R2: `aHit` is high, combinationally, exactly when `aAddr` is in 0x1000–0x4FFF. Bank 0 is at 0x1000, bank 1 at 0x2000, bank 2 at 0x3000 and bank 3 at 0x4000.
- R3: On side A, address bits 11:10 are ignored. Each 1 KB bank repeats four times through its 4 KB region, with the byte offset taken from `aAddr[9:0]`. For example, 0x1C25 and 0x1025 name the same byte.
- R4: `bHit` is high exactly when `bAddr` is in 0x0400–0x13FF. The bank number is `bAddr[12:10]` minus 1, and the offset is `bAddr[9:0]`. Side B A-address 0x1000+k and side B address 0x0400+k therefore name the same byte.
- R5: Side A's access takes effect only in a cycle where `phase` is 0, and side B's only in a cycle where `phase` is 1. A valid request presented in the other phase changes neither the RAM nor the read data.
- R6: A hitting read performed in a side's phase appears on that side's read-data port from the next cycle on. The value holds until that side's next hitting read, and writes do not change it.
- R7: A side A write in a phase-0 cycle is returned by a side B read of the same byte in the immediately following phase-1 cycle.
- R8: An access that does not hit writes nothing and leaves that side's read data unchanged.
- R9: `aPrivate` equals `aValid` and not `aHit`; `bPrivate` equals `bValid` and not `bHit`.
- R10: Both read-data ports are 0 during and immediately after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| aAddr | input | 16 | Side A address |
| aWdata | input | 8 | Side A write data |
| aWe | input | 1 | Side A write enable (1 = write, 0 = read) |
| aValid | input | 1 | Side A access valid |
| aRdata | output | 8 | Side A read data, registered |
| aHit | output | 1 | Side A address is in a shared window |
| aPrivate | output | 1 | Side A valid access outside the shared windows |
| bAddr | input | 16 | Side B address |
| bWdata | input | 8 | Side B write data |
| bWe | input | 1 | Side B write enable (1 = write, 0 = read) |
| bValid | input | 1 | Side B access valid |
| bRdata | output | 8 | Side B read data, registered |
| bHit | output | 1 | Side B address is in a shared window |
| bPrivate | output | 1 | Side B valid access outside the shared windows |
| phase | output | 1 | Current owner: 0 = side A, 1 = side B |

## Verification
A phase register that is stuck, or that starts at the wrong value after reset, shows at once: either `phase` fails to alternate, or an access made in its proper phase is lost or lands in the wrong cycle. A wrong bank or offset shows up as a mismatched byte on the next read through the mirrored address of either side, within two cycles of the write. A read-data register that loads on the wrong strobe shows up as a changed `aRdata` or `bRdata` in the cycle after an idle, write, missing or off-phase access.

// File: rtl/shram_pkg.sv
package shram_pkg;
  localparam int ADDR_W_DEF    = 16;
  localparam int DATA_W_DEF    = 8;
  localparam int BANK_LOG2_DEF = 10;
  localparam int NUM_BANKS_DEF = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic ownerB;  // 1: side B drives the RAM this cycle
    logic ramEn;   // RAM access this cycle
    logic ramWe;   // RAM write this cycle
    logic loadA;   // capture read data for side A
    logic loadB;   // capture read data for side B
  } ramStrobe_t;
endpackage

// File: rtl/shram_window_dec.sv
module shram_window_dec #(
  parameter int ADDR_W       = 16,
  parameter int REGION_LOG2  = 12,
  parameter int BANK_LOG2    = 10,
  parameter int FIRST_REGION = 1,
  parameter int NUM_BANKS    = 4,
  localparam int BSEL_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int RIDX_W      = ADDR_W - REGION_LOG2
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic [BSEL_W-1:0]    bank,
  output logic [BANK_LOG2-1:0] offset
);
  logic [RIDX_W-1:0] regionIdx;
  logic [RIDX_W-1:0] relIdx;

  assign regionIdx = addr[ADDR_W-1:REGION_LOG2];
  // Below the first region this wraps to a large value and misses
  assign relIdx    = regionIdx - RIDX_W'(FIRST_REGION);
  assign hit       = (relIdx < RIDX_W'(NUM_BANKS));
  assign bank      = relIdx[BSEL_W-1:0];
  // Bits between BANK_LOG2 and REGION_LOG2 are don't-care: mirroring
  assign offset    = addr[BANK_LOG2-1:0];
endmodule

// File: rtl/shram_phase_ctrl.sv
module shram_phase_ctrl
  import shram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       aValid,
  input  logic       aWe,
  input  logic       aHit,
  input  logic       bValid,
  input  logic       bWe,
  input  logic       bHit,
  output logic       phase,
  output ramStrobe_t strobe
);
  logic ownAccess;
  logic ownWrite;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= ~phase;
  end

  always_comb begin
    ownAccess     = phase ? (bValid && bHit) : (aValid && aHit);
    ownWrite      = phase ? bWe : aWe;
    strobe.ownerB = phase;
    strobe.ramEn  = ownAccess;
    strobe.ramWe  = ownAccess && ownWrite;
    strobe.loadA  = ownAccess && !ownWrite && !phase;
    strobe.loadB  = ownAccess && !ownWrite && phase;
  end

  p_phase_toggle_r1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (phase != $past(phase)));
endmodule

// File: rtl/shram_datapath.sv
module shram_datapath
  import shram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BANK_LOG2 = 10,
  parameter int NUM_BANKS = 4,
  localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int RAM_AW   = BSEL_W + BANK_LOG2,
  localparam int DEPTH    = NUM_BANKS << BANK_LOG2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ramStrobe_t           strobe,
  input  logic [BSEL_W-1:0]    aBank,
  input  logic [BANK_LOG2-1:0] aOffset,
  input  logic [DATA_W-1:0]    aWdata,
  input  logic [BSEL_W-1:0]    bBank,
  input  logic [BANK_LOG2-1:0] bOffset,
  input  logic [DATA_W-1:0]    bWdata,
  output logic [DATA_W-1:0]    aRdata,
  output logic [DATA_W-1:0]    bRdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [RAM_AW-1:0] ramAddr;
  logic [DATA_W-1:0] ramWdata;
  logic [DATA_W-1:0] ramRdata;

  // Address and data switch with the owning phase
  assign ramAddr  = strobe.ownerB ? {bBank, bOffset} : {aBank, aOffset};
  assign ramWdata = strobe.ownerB ? bWdata : aWdata;
  assign ramRdata = mem[ramAddr];

  always_ff @(posedge clk) begin
    if (strobe.ramWe) mem[ramAddr] <= ramWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aRdata <= '0;
      bRdata <= '0;
    end else begin
      if (strobe.loadA) aRdata <= ramRdata;
      if (strobe.loadB) bRdata <= ramRdata;
    end
  end

  p_a_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadA |=> $stable(aRdata));
  p_b_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadB |=> $stable(bRdata));
endmodule

// File: rtl/phase_shared_ram.sv
module phase_shared_ram
  import shram_pkg::*;
#(
  parameter int ADDR_W        = ADDR_W_DEF,
  parameter int DATA_W        = DATA_W_DEF,
  parameter int BANK_LOG2     = BANK_LOG2_DEF,
  parameter int NUM_BANKS     = NUM_BANKS_DEF,
  parameter int A_REGION_LOG2 = 12,
  parameter int A_FIRST       = 1,
  parameter int B_REGION_LOG2 = 10,
  parameter int B_FIRST       = 1,
  localparam int BSEL_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  input  logic              aWe,
  input  logic              aValid,
  output logic [DATA_W-1:0] aRdata,
  output logic              aHit,
  output logic              aPrivate,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  input  logic              bWe,
  input  logic              bValid,
  output logic [DATA_W-1:0] bRdata,
  output logic              bHit,
  output logic              bPrivate,
  output logic              phase
);
  logic [BSEL_W-1:0]    aBank, bBank;
  logic [BANK_LOG2-1:0] aOffset, bOffset;
  ramStrobe_t           ramStrobe;

  shram_window_dec #(
    .ADDR_W(ADDR_W), .REGION_LOG2(A_REGION_LOG2), .BANK_LOG2(BANK_LOG2),
    .FIRST_REGION(A_FIRST), .NUM_BANKS(NUM_BANKS)
  ) uDecA (.addr(aAddr), .hit(aHit), .bank(aBank), .offset(aOffset));

  shram_window_dec #(
    .ADDR_W(ADDR_W), .REGION_LOG2(B_REGION_LOG2), .BANK_LOG2(BANK_LOG2),
    .FIRST_REGION(B_FIRST), .NUM_BANKS(NUM_BANKS)
  ) uDecB (.addr(bAddr), .hit(bHit), .bank(bBank), .offset(bOffset));

  shram_phase_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .aValid(aValid), .aWe(aWe), .aHit(aHit),
    .bValid(bValid), .bWe(bWe), .bHit(bHit),
    .phase(phase), .strobe(ramStrobe)
  );

  shram_datapath #(
    .DATA_W(DATA_W), .BANK_LOG2(BANK_LOG2), .NUM_BANKS(NUM_BANKS)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(ramStrobe),
    .aBank(aBank), .aOffset(aOffset), .aWdata(aWdata),
    .bBank(bBank), .bOffset(bOffset), .bWdata(bWdata),
    .aRdata(aRdata), .bRdata(bRdata)
  );

  assign aPrivate = aValid && !aHit;
  assign bPrivate = bValid && !bHit;

  p_a_write_phase_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!phase && ramStrobe.ramWe) |-> (aValid && aWe && aHit));
  p_b_write_phase_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase && ramStrobe.ramWe) |-> (bValid && bWe && bHit));
  p_private_no_ram_r9: assert property (@(posedge clk) disable iff (!rstN)
    aPrivate |-> (!ramStrobe.ramEn || phase));
endmodule

// File: tb/tb_phase_shared_ram.sv
`timescale 1ns/1ps
module tb_phase_shared_ram;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] aAddr = '0, bAddr = '0;
  logic [7:0]  aWdata = '0, bWdata = '0;
  logic        aWe = 1'b0, bWe = 1'b0, aValid = 1'b0, bValid = 1'b0;
  logic [7:0]  aRdata, bRdata;
  logic        aHit, bHit, aPrivate, bPrivate, phase;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  phase_shared_ram dut (
    .clk(clk), .rstN(rstN),
    .aAddr(aAddr), .aWdata(aWdata), .aWe(aWe), .aValid(aValid),
    .aRdata(aRdata), .aHit(aHit), .aPrivate(aPrivate),
    .bAddr(bAddr), .bWdata(bWdata), .bWe(bWe), .bValid(bValid),
    .bRdata(bRdata), .bHit(bHit), .bPrivate(bPrivate), .phase(phase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitPhase(input logic p);
    @(negedge clk);
    while (phase != p) @(negedge clk);
  endtask

  task automatic aWrite(input logic [15:0] ad, input logic [7:0] d);
    waitPhase(1'b0);
    aAddr = ad; aWdata = d; aWe = 1'b1; aValid = 1'b1;
    @(negedge clk);
    aValid = 1'b0; aWe = 1'b0;
  endtask

  task automatic bWrite(input logic [15:0] ad, input logic [7:0] d);
    waitPhase(1'b1);
    bAddr = ad; bWdata = d; bWe = 1'b1; bValid = 1'b1;
    @(negedge clk);
    bValid = 1'b0; bWe = 1'b0;
  endtask

  task automatic aRead(input logic [15:0] ad, output logic [7:0] d);
    waitPhase(1'b0);
    aAddr = ad; aWe = 1'b0; aValid = 1'b1;
    @(negedge clk);
    aValid = 1'b0;
    d = aRdata;
  endtask

  task automatic bRead(input logic [15:0] ad, output logic [7:0] d);
    waitPhase(1'b1);
    bAddr = ad; bWe = 1'b0; bValid = 1'b1;
    @(negedge clk);
    bValid = 1'b0;
    d = bRdata;
  endtask

  // R10, R1: reset state and toggling
  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(phase == 1'b0, "R1 phase in reset", phase, 0);
    check(aRdata == 8'h00, "R10 aRdata in reset", aRdata, 0);
    check(bRdata == 8'h00, "R10 bRdata in reset", bRdata, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(phase == 1'b1, "R1 first phase after reset", phase, 1);
    check(aRdata == 8'h00 && bRdata == 8'h00, "R10 rdata after reset", {aRdata, bRdata}, 0);
    for (int i = 0; i < 6; i++) begin
      logic prev = phase;
      @(negedge clk);
      check(phase == ~prev, "R1 phase toggles", phase, ~prev);
    end
  endtask

  // R2, R4, R9: window decoding on both sides
  task automatic tDecode();
    logic [15:0] probes [12] = '{16'h0000, 16'h03FF, 16'h0400, 16'h0FFF,
                                 16'h1000, 16'h13FF, 16'h1400, 16'h2ABC,
                                 16'h4FFF, 16'h5000, 16'h8000, 16'hFFFF};
    @(negedge clk);
    aValid = 1'b0; bValid = 1'b0;
    for (int i = 0; i < 12; i++) begin
      int x = probes[i];
      bit eA = (x >= 'h1000) && (x < 'h5000);
      bit eB = (x >= 'h0400) && (x < 'h1400);
      aAddr = probes[i]; bAddr = probes[i];
      #1;
      check(aHit == eA, "R2 aHit decode", aHit, eA);
      check(bHit == eB, "R4 bHit decode", bHit, eB);
      check(aPrivate == 1'b0 && bPrivate == 1'b0, "R9 private idle", {aPrivate, bPrivate}, 0);
      aValid = 1'b1; bValid = 1'b1;
      #1;
      check(aPrivate == !eA, "R9 aPrivate", aPrivate, !eA);
      check(bPrivate == !eB, "R9 bPrivate", bPrivate, !eB);
      aValid = 1'b0; bValid = 1'b0;
    end
  endtask

  // R3, R4, R6: bank mapping, mirrors, read path
  task automatic tMapping();
    logic [7:0] d;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] aBase = 16'(('h1000 * (k + 1)) + 'h025 + k);
      logic [15:0] bBase = 16'(('h0400 * (k + 1)) + 'h025 + k);
      aWrite(aBase, 8'(8'hA0 + k));
      bRead(bBase, d);
      check(d == 8'(8'hA0 + k), "R4 side B sees bank", d, 8'hA0 + k);
      aRead(aBase | 16'h0C00, d);
      check(d == 8'(8'hA0 + k), "R3 top mirror", d, 8'hA0 + k);
      aRead(aBase | 16'h0400, d);
      check(d == 8'(8'hA0 + k), "R3 mid mirror", d, 8'hA0 + k);
    end
    bWrite(16'h13FF, 8'h5A);
    aRead(16'h4FFF, d);
    check(d == 8'h5A, "R3 R4 last byte both sides", d, 8'h5A);
  endtask

  // R7: write in phase 0, read by B in the very next phase
  task automatic tBackToBack();
    waitPhase(1'b0);
    aAddr = 16'h3177; aWdata = 8'hC3; aWe = 1'b1; aValid = 1'b1;
    @(negedge clk);
    aValid = 1'b0; aWe = 1'b0;
    check(phase == 1'b1, "R7 next phase is B", phase, 1);
    bAddr = 16'h0D77; bWe = 1'b0; bValid = 1'b1;
    @(negedge clk);
    bValid = 1'b0;
    check(bRdata == 8'hC3, "R7 same-beat visibility", bRdata, 8'hC3);
  endtask

  // R5: requests in the wrong phase are ignored
  task automatic tOffPhase();
    logic [7:0] d;
    aWrite(16'h2010, 8'h11);
    aRead(16'h2010, d);
    waitPhase(1'b1);
    aAddr = 16'h2010; aWdata = 8'hEE; aWe = 1'b1; aValid = 1'b1;
    @(negedge clk);
    aValid = 1'b0; aWe = 1'b0;
    bRead(16'h0810, d);
    check(d == 8'h11, "R5 A write in phase 1 ignored", d, 8'h11);
    waitPhase(1'b0);
    bAddr = 16'h0810; bWdata = 8'h77; bWe = 1'b1; bValid = 1'b1;
    @(negedge clk);
    bValid = 1'b0; bWe = 1'b0;
    aRead(16'h2010, d);
    check(d == 8'h11, "R5 B write in phase 0 ignored", d, 8'h11);
    bWrite(16'h0C00, 8'h99);
    bRead(16'h0810, d);
    check(d == 8'h11, "R5 bRdata before off-phase read", d, 8'h11);
    waitPhase(1'b0);
    bAddr = 16'h0C00; bWe = 1'b0; bValid = 1'b1;
    @(negedge clk);
    bValid = 1'b0;
    @(negedge clk);
    check(bRdata == 8'h11, "R5 B read in phase 0 ignored", bRdata, 8'h11);
  endtask

  // R6, R8: read data holds; misses write nothing
  task automatic tHoldAndMiss();
    logic [7:0] d;
    aWrite(16'h1300, 8'h3C);
    aWrite(16'h4300, 8'h4C);
    aRead(16'h1300, d);
    check(d == 8'h3C, "R6 read returns data", d, 8'h3C);
    aWrite(16'h1301, 8'h66);
    bWrite(16'h0702, 8'h67);
    repeat (3) @(negedge clk);
    check(aRdata == 8'h3C, "R6 aRdata holds over writes", aRdata, 8'h3C);
    aWrite(16'h5300, 8'hF0);
    aWrite(16'h0300, 8'hF1);
    bWrite(16'h1700, 8'hF2);
    bWrite(16'h0300, 8'hF3);
    aRead(16'h0300, d);
    check(d == 8'h3C, "R8 miss read keeps aRdata", d, 8'h3C);
    aRead(16'h4300, d);
    check(d == 8'h4C, "R8 bank 3 untouched by misses", d, 8'h4C);
    aRead(16'h1300, d);
    check(d == 8'h3C, "R8 bank 0 untouched by misses", d, 8'h3C);
    bRead(16'h1300, d);
    check(d == 8'h4C, "R8 side B view untouched", d, 8'h4C);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tDecode();
    tMapping();
    tBackToBack();
    tOffPhase();
    tHoldAndMiss();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule